// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions in a speculative out-of-order core. When the front end issues an instruction, the block allocates the next slot of a circular buffer. The slot records two things: what kind of instruction it is (register-writing ALU or load, store, or branch) and, for a register-writing instruction, the destination register number. The slot index goes back to the front end. From then on it is the rename tag that later instructions wait on, in place of a reservation-station tag.

Execution units return results on a writeback bus tagged with that slot index. Dependent instructions can read a finished result through a lookup port before it retires. Retirement takes place only at the head, one entry per cycle, and only once the head's result is present:

- A register result goes out on a register write port.
- A store goes out on a memory write port. It is the only point at which memory is ever written.
- A branch found mispredicted, or any entry that reported an exception, empties the whole buffer. A mispredicted branch also drives a redirect address.

All retirement outputs are registered.

Top module: `rob_unit`

## Requirements
- R1: After a synchronous reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, and `cm_reg_we`, `cm_mem_we`, `cm_exc` and `flush_o` are 0.
- R2: An issue with `iss_valid` high and `iss_ready` high takes slot `iss_tag`. After that edge `iss_tag` is the old value plus one, modulo DEPTH. With DEPTH entries outstanding, `iss_ready` is 0 and an issue is ignored: `iss_tag` does not move.
- R3: A writeback (`wb_valid`) to a live slot `wb_tag` stores `wb_value`, `wb_addr`, `wb_exc` and `wb_mispred`, and marks the slot ready. A writeback to a free slot is ignored: that slot is still not ready after it is next allocated.
- R4: `src_ready` and `src_value` report, in the same cycle, whether slot `src_tag` is live and holds a result, and what that result is.
- R5: Entries retire strictly from the head, at most one per edge, and only when the head is ready. Younger ready entries wait. Retirement outputs appear for one cycle after the edge at which a ready head retires.
- R6: A retiring entry of kind 0 (ALU/load) pulses `cm_reg_we` with `cm_reg_idx` equal to its destination and `cm_reg_data` equal to its value.
- R7: A retiring entry of kind 1 (store) pulses `cm_mem_we` with `cm_mem_addr` equal to its writeback address and `cm_mem_data` equal to its value. `cm_mem_we` is never high for a store that has not reached retirement.
- R8: A retiring entry of kind 2 (branch) whose `wb_mispred` was 0 leaves the buffer and drives no write and no flush.
- R9: A retiring branch whose `wb_mispred` was 1 pulses `flush_o`, with `redirect_pc` equal to its writeback address. Every younger entry is dropped without any write, the buffer becomes empty, and the next allocated tag is the index after the branch.
- R10: A retiring entry whose `wb_exc` was 1 pulses `cm_exc` together with `flush_o`. It writes neither registers nor memory, and the buffer empties as in R9.
- R11: An issue presented at the same edge as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Kind: 0 ALU/load, 1 store, 2 branch |
| iss_dest | input | REG_W | Destination register for kind 0 |
| iss_ready | output | 1 | Buffer has a free slot |
| iss_tag | output | TAG_W | Slot (rename tag) given to the current issue |
| wb_valid | input | 1 | Writeback bus valid |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_value | input | DATA_W | Result value or store data |
| wb_addr | input | ADDR_W | Store address or correct branch target |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispred | input | 1 | Branch was mispredicted |
| src_tag | input | TAG_W | Operand lookup tag |
| src_ready | output | 1 | Looked-up slot holds a result |
| src_value | output | DATA_W | Looked-up result |
| cm_reg_we | output | 1 | Register write at retirement |
| cm_reg_idx | output | REG_W | Register number |
| cm_reg_data | output | DATA_W | Register data |
| cm_mem_we | output | 1 | Memory write at retirement |
| cm_mem_addr | output | ADDR_W | Memory address |
| cm_mem_data | output | DATA_W | Memory data |
| cm_exc | output | 1 | Precise exception taken |
| flush_o | output | 1 | Buffer flushed this cycle |
| redirect_pc | output | ADDR_W | Fetch redirect address on misprediction |

## Verification
The bench builds the buffer with DEPTH = 4, 16-bit data and addresses, and 5-bit register numbers. With only four slots, filling the buffer, stalling issue, wrapping the pointers and reusing freed slots each take a handful of cycles. A short table of mixed ALU, store and branch entries is written back in reverse order, so in-order retirement and forwarding are visible. Directed sequences then cover a misprediction with a coincident issue, a writeback to a freed slot, and an exception at the head.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head and tail pointers, one bit wider than the slot index.
module rob_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [AW-1:0] head_idx,
  output logic [AW-1:0] tail_idx,
  output logic          full
);
  logic [AW:0] head_q, tail_q, head_nx;

  assign head_nx = head_q + (AW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      // the flushing entry leaves along with everything younger
      head_q <= head_nx;
      tail_q <= head_nx;
    end else begin
      if (pop)  head_q <= head_nx;
      if (push) tail_q <= tail_q + (AW+1)'(1);
    end
  end

  assign head_idx = head_q[AW-1:0];
  assign tail_idx = tail_q[AW-1:0];
  assign full     = (head_q[AW] != tail_q[AW]) && (head_idx == tail_idx);
endmodule

// File: rtl/rob_ram.sv
// Slot payload storage: one write port, RD_PORTS asynchronous read ports.
module rob_ram #(
  parameter int WIDTH    = 8,
  parameter int DEPTH    = 16,
  parameter int RD_PORTS = 1,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [RD_PORTS*AW-1:0]    raddr,
  output logic [RD_PORTS*WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p*WIDTH +: WIDTH] = mem[raddr[p*AW +: AW]];
  end
endmodule

// File: rtl/rob_flags.sv
// Per-slot live and result-present bits.
module rob_flags #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [AW-1:0]    alloc_idx,
  input  logic             retire_en,
  input  logic [AW-1:0]    retire_idx,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_idx,
  output logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] done
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        live[i] <= 1'b0;
        done[i] <= 1'b0;
      end else begin
        if (alloc_en && alloc_idx == AW'(i)) live[i] <= 1'b1;
        if (wb_en && wb_idx == AW'(i))       done[i] <= 1'b1;
        // done is cleared when the slot is freed, not when it is allocated
        if (retire_en && retire_idx == AW'(i)) begin
          live[i] <= 1'b0;
          done[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rob_unit.sv
module rob_unit #(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     iss_valid,
  input  logic [1:0]               iss_kind,
  input  logic [REG_W-1:0]         iss_dest,
  output logic                     iss_ready,
  output logic [$clog2(DEPTH)-1:0] iss_tag,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_tag,
  input  logic [DATA_W-1:0]        wb_value,
  input  logic [ADDR_W-1:0]        wb_addr,
  input  logic                     wb_exc,
  input  logic                     wb_mispred,
  input  logic [$clog2(DEPTH)-1:0] src_tag,
  output logic                     src_ready,
  output logic [DATA_W-1:0]        src_value,
  output logic                     cm_reg_we,
  output logic [REG_W-1:0]         cm_reg_idx,
  output logic [DATA_W-1:0]        cm_reg_data,
  output logic                     cm_mem_we,
  output logic [ADDR_W-1:0]        cm_mem_addr,
  output logic [DATA_W-1:0]        cm_mem_data,
  output logic                     cm_exc,
  output logic                     flush_o,
  output logic [ADDR_W-1:0]        redirect_pc
);
  import rob_pkg::*;

  localparam int TAG_W  = $clog2(DEPTH);
  localparam int META_W = 2 + REG_W;
  localparam int RES_W  = 2 + ADDR_W + DATA_W;

  logic [TAG_W-1:0] head_idx, tail_idx;
  logic             full;
  logic [DEPTH-1:0] live, done;

  logic             push, pop, do_retire, do_flush, wb_en;
  logic [META_W-1:0] meta_h;
  logic [2*RES_W-1:0] res_rd;
  logic [RES_W-1:0]  res_h, res_s;

  kind_e             h_kind;
  logic [REG_W-1:0]  h_dest;
  logic              h_exc, h_mp;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_value;

  // ---------------- pointers and flags ----------------
  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(do_flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full)
  );

  rob_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .flush(do_flush),
    .alloc_en(push), .alloc_idx(tail_idx),
    .retire_en(pop), .retire_idx(head_idx),
    .wb_en(wb_en), .wb_idx(wb_tag),
    .live(live), .done(done)
  );

  // ---------------- payload storage ----------------
  // issue-time fields: kind and destination, read at the head
  rob_ram #(.WIDTH(META_W), .DEPTH(DEPTH), .RD_PORTS(1)) u_meta (
    .clk(clk), .we(push), .waddr(tail_idx),
    .wdata({iss_kind, iss_dest}),
    .raddr(head_idx), .rdata(meta_h)
  );

  // writeback-time fields, read at the head and at the operand lookup
  rob_ram #(.WIDTH(RES_W), .DEPTH(DEPTH), .RD_PORTS(2)) u_res (
    .clk(clk), .we(wb_en), .waddr(wb_tag),
    .wdata({wb_exc, wb_mispred, wb_addr, wb_value}),
    .raddr({src_tag, head_idx}), .rdata(res_rd)
  );

  assign res_h = res_rd[RES_W-1:0];
  assign res_s = res_rd[2*RES_W-1:RES_W];

  assign h_kind  = kind_e'(meta_h[META_W-1 -: 2]);
  assign h_dest  = meta_h[REG_W-1:0];
  assign h_exc   = res_h[RES_W-1];
  assign h_mp    = res_h[RES_W-2];
  assign h_addr  = res_h[DATA_W +: ADDR_W];
  assign h_value = res_h[DATA_W-1:0];

  // ---------------- control ----------------
  assign wb_en     = wb_valid && live[wb_tag];
  assign do_retire = live[head_idx] && done[head_idx];
  assign do_flush  = do_retire && (h_exc || (h_kind == K_BRANCH && h_mp));
  assign pop       = do_retire && !do_flush;
  assign push      = iss_valid && !full && !do_flush;

  assign iss_ready = !full;
  assign iss_tag   = tail_idx;
  assign src_ready = live[src_tag] && done[src_tag];
  assign src_value = res_s[DATA_W-1:0];

  // ---------------- registered retirement outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cm_reg_we   <= 1'b0;
      cm_reg_idx  <= '0;
      cm_reg_data <= '0;
      cm_mem_we   <= 1'b0;
      cm_mem_addr <= '0;
      cm_mem_data <= '0;
      cm_exc      <= 1'b0;
      flush_o     <= 1'b0;
      redirect_pc <= '0;
    end else begin
      cm_reg_we   <= pop && (h_kind == K_ALU);
      cm_mem_we   <= pop && (h_kind == K_STORE);
      cm_exc      <= do_retire && h_exc;
      flush_o     <= do_flush;
      if (pop) begin
        cm_reg_idx  <= h_dest;
        cm_reg_data <= h_value;
        cm_mem_addr <= h_addr;
        cm_mem_data <= h_value;
      end
      if (do_flush) redirect_pc <= h_addr;
    end
  end
endmodule

// File: rtl/rob_unit_checker.sv
module rob_unit_checker #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [TAG_W-1:0] iss_tag,
  input logic             cm_reg_we,
  input logic             cm_mem_we,
  input logic             cm_exc,
  input logic             flush_o
);
  // R1: reset leaves an empty buffer and quiet outputs
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (iss_ready && iss_tag == '0 && !flush_o && !cm_reg_we && !cm_mem_we));

  // R2: an accepted issue advances the tag by one
  a_r2_tag_advance: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> (flush_o || iss_tag == TAG_W'($past(iss_tag) + 1'b1)));

  // R2: no accepted issue, no tag movement
  a_r2_tag_hold: assert property (@(posedge clk) disable iff (rst)
    (!iss_valid || !iss_ready) |=> (flush_o || $stable(iss_tag)));

  // R6, R7, R9: one retirement effect at a time
  a_r6_single_effect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cm_reg_we, cm_mem_we, flush_o}));

  // R9: a flush leaves the buffer empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> iss_ready);

  // R10: an exception always comes with a flush
  a_r10_exc_flushes: assert property (@(posedge clk) disable iff (rst)
    cm_exc |-> (flush_o && !cm_reg_we && !cm_mem_we));
endmodule

bind rob_unit rob_unit_checker #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .cm_reg_we(cm_reg_we), .cm_mem_we(cm_mem_we),
  .cm_exc(cm_exc), .flush_o(flush_o)
);

// File: tb/rob_unit_bench.sv
module rob_unit_bench;
  localparam int DEPTH = 4;
  localparam int REG_W = 5;
  localparam int DW    = 16;
  localparam int AW    = 16;
  localparam int TW    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [1:0] iss_kind = '0;
  logic [REG_W-1:0] iss_dest = '0;
  logic iss_ready;
  logic [TW-1:0] iss_tag;
  logic wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [DW-1:0] wb_value = '0;
  logic [AW-1:0] wb_addr = '0;
  logic wb_exc = 1'b0;
  logic wb_mispred = 1'b0;
  logic [TW-1:0] src_tag = '0;
  logic src_ready;
  logic [DW-1:0] src_value;
  logic cm_reg_we, cm_mem_we, cm_exc, flush_o;
  logic [REG_W-1:0] cm_reg_idx;
  logic [DW-1:0] cm_reg_data, cm_mem_data;
  logic [AW-1:0] cm_mem_addr, redirect_pc;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5ns clk = ~clk;

  rob_unit #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DW), .ADDR_W(AW)) u_rob_unit (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_addr(wb_addr),
    .wb_exc(wb_exc), .wb_mispred(wb_mispred),
    .src_tag(src_tag), .src_ready(src_ready), .src_value(src_value),
    .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx), .cm_reg_data(cm_reg_data),
    .cm_mem_we(cm_mem_we), .cm_mem_addr(cm_mem_addr), .cm_mem_data(cm_mem_data),
    .cm_exc(cm_exc), .flush_o(flush_o), .redirect_pc(redirect_pc)
  );

  // table: kind (0 ALU, 1 store, 2 branch), dest, value, address, expected writes
  localparam logic [1:0]       T_KIND [4] = '{2'd0, 2'd1, 2'd2, 2'd0};
  localparam logic [REG_W-1:0] T_DEST [4] = '{5'd3, 5'd0, 5'd0, 5'd7};
  localparam logic [DW-1:0]    T_VAL  [4] = '{16'h1111, 16'h2222, 16'h0000, 16'h4444};
  localparam logic [AW-1:0]    T_ADDR [4] = '{16'h0000, 16'h0080, 16'h0000, 16'h0000};
  localparam logic             T_RW   [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic             T_MW   [4] = '{1'b0, 1'b1, 1'b0, 1'b0};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_inputs();
    iss_valid = 1'b0; iss_kind = '0; iss_dest = '0;
    wb_valid = 1'b0; wb_tag = '0; wb_value = '0; wb_addr = '0;
    wb_exc = 1'b0; wb_mispred = 1'b0;
  endtask

  task automatic do_idle();
    @(negedge clk); clear_inputs();
    @(posedge clk); #1ns;
  endtask

  task automatic do_issue(input logic [1:0] k, input logic [REG_W-1:0] d);
    @(negedge clk); clear_inputs();
    iss_valid = 1'b1; iss_kind = k; iss_dest = d;
    @(posedge clk); #1ns;
  endtask

  task automatic do_wb(input logic [TW-1:0] t, input logic [DW-1:0] v,
                       input logic [AW-1:0] a, input logic e, input logic m);
    @(negedge clk); clear_inputs();
    wb_valid = 1'b1; wb_tag = t; wb_value = v; wb_addr = a; wb_exc = e; wb_mispred = m;
    @(posedge clk); #1ns;
  endtask

  task automatic set_src(input logic [TW-1:0] t);
    src_tag = t; #1ns;
  endtask

  initial begin
    #100us;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1ns;
    // R1 reset state
    chk("R1", 32'(iss_ready), 32'd1);
    chk("R1", 32'(iss_tag), 32'd0);
    chk("R1", 32'({cm_reg_we, cm_mem_we, cm_exc, flush_o}), 32'd0);

    // table walk: fill the buffer in circular order (R2)
    for (int i = 0; i < 4; i++) begin
      chk("R2", 32'(iss_tag), 32'(i));
      do_issue(T_KIND[i], T_DEST[i]);
    end
    chk("R2", 32'(iss_ready), 32'd0);
    do_issue(2'd0, 5'd9);               // ignored while full
    chk("R2", 32'(iss_tag), 32'd0);
    chk("R2", 32'(iss_ready), 32'd0);

    // results arrive youngest first: nothing may retire (R5, R7)
    for (int i = 3; i > 0; i--) begin
      do_wb(TW'(i), T_VAL[i], T_ADDR[i], 1'b0, 1'b0);
      chk("R5", 32'({cm_reg_we, cm_mem_we, flush_o}), 32'd0);
      chk("R7", 32'(cm_mem_we), 32'd0);
    end
    set_src(2'd2);
    chk("R4", 32'(src_ready), 32'd1);
    chk("R4", 32'(src_value), 32'(T_VAL[2]));
    set_src(2'd0);
    chk("R4", 32'(src_ready), 32'd0);

    do_wb(2'd0, T_VAL[0], T_ADDR[0], 1'b0, 1'b0);
    chk("R5", 32'({cm_reg_we, cm_mem_we}), 32'd0);

    // in-order retirement, one entry per cycle (R5, R6, R7, R8)
    for (int i = 0; i < 4; i++) begin
      do_idle();
      chk("R6", 32'(cm_reg_we), 32'(T_RW[i]));
      chk("R7", 32'(cm_mem_we), 32'(T_MW[i]));
      chk("R8", 32'(flush_o), 32'd0);
      if (T_RW[i]) begin
        chk("R6", 32'(cm_reg_idx), 32'(T_DEST[i]));
        chk("R6", 32'(cm_reg_data), 32'(T_VAL[i]));
      end
      if (T_MW[i]) begin
        chk("R7", 32'(cm_mem_addr), 32'(T_ADDR[i]));
        chk("R7", 32'(cm_mem_data), 32'(T_VAL[i]));
      end
    end
    do_idle();
    chk("R5", 32'({cm_reg_we, cm_mem_we}), 32'd0);
    chk("R2", 32'(iss_ready), 32'd1);
    chk("R2", 32'(iss_tag), 32'd0);

    // mispredicted branch at tag 1 (R9, R11)
    do_issue(2'd0, 5'd5);
    do_issue(2'd2, 5'd0);
    do_issue(2'd0, 5'd6);
    do_wb(2'd2, 16'h6666, 16'h0000, 1'b0, 1'b0);
    do_wb(2'd0, 16'h5555, 16'h0000, 1'b0, 1'b0);
    do_wb(2'd1, 16'h0000, 16'h4000, 1'b0, 1'b1);
    chk("R6", 32'(cm_reg_we), 32'd1);
    chk("R6", 32'(cm_reg_data), 32'h5555);
    do_issue(2'd0, 5'd8);               // lands on the flush edge
    chk("R9", 32'(flush_o), 32'd1);
    chk("R9", 32'(redirect_pc), 32'h4000);
    chk("R9", 32'(cm_reg_we), 32'd0);
    chk("R9", 32'(iss_ready), 32'd1);
    chk("R11", 32'(iss_tag), 32'd2);
    do_idle();
    chk("R9", 32'({cm_reg_we, cm_mem_we, flush_o}), 32'd0);

    // writeback to a freed slot is ignored (R3)
    do_wb(2'd2, 16'h7777, 16'h0000, 1'b0, 1'b0);
    do_issue(2'd0, 5'd9);
    set_src(2'd2);
    chk("R3", 32'(src_ready), 32'd0);
    do_idle();
    chk("R3", 32'(cm_reg_we), 32'd0);

    // exception at the head (R10)
    do_wb(2'd2, 16'h8888, 16'h0000, 1'b1, 1'b0);
    set_src(2'd2);
    chk("R4", 32'(src_ready), 32'd1);
    chk("R4", 32'(src_value), 32'h8888);
    do_idle();
    chk("R10", 32'(cm_exc), 32'd1);
    chk("R10", 32'(flush_o), 32'd1);
    chk("R10", 32'({cm_reg_we, cm_mem_we}), 32'd0);
    chk("R10", 32'(iss_tag), 32'd3);
    do_idle();
    chk("R10", 32'(cm_exc), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule